// File: doc/BRIEF.md
# Multi-Stack Call/Return Unit

This unit carries out subroutine calls and returns for a small core that runs several hardware tasks in turn. Each request names an opcode, the issuing task, a call target and the return address to save. The opcode picks one of five stack disciplines:

- a private shallow return stack for each task;
- two pointer stacks (A, B) kept in a large shared memory;
- two pointer stacks (X, Y) kept in a small auxiliary memory.

The Y stack grows down from the top of the auxiliary memory because its pointer is presented inverted.

For each request the unit produces the next program counter. On every call it also records the return address in a per-task link register, which can be read through a separate read port. Plain calls and returns on the shallow stack finish without a stall. Requests that touch a memory hold `busy` high until that memory answers with ready.

Top module: `callret_unit`

## Requirements
- R1: Opcode 0 (call, shallow stack) pushes the return address onto the issuing task's stack. One cycle after acceptance, `done` pulses and `next_pc` equals the target. `busy` is never raised.
- R2: Opcode 1 (return, shallow stack) pops the issuing task's stack. One cycle after acceptance, `done` pulses and `next_pc` holds the most recently pushed value. The stacks of the four tasks are independent.
- R3: A shallow stack holds 4 entries. A push onto a full stack silently drops the oldest entry, and the last four pushed values come back in reverse order.
- R4: The shallow stack pointer wraps modulo 4, so a pop from an empty stack returns the stale slot value. After pushes v0..v4 and four pops, a fifth pop returns v4 again.
- R5: Opcodes 2 (A) and 4 (B) write the return address to shared memory at the current pointer value with `sm_we`=1, then increment that pointer. `next_pc` equals the target.
- R6: Opcodes 3 (A) and 5 (B) decrement the pointer first, then read shared memory at the new value with `sm_we`=0. `next_pc` equals the read data.
- R7: Opcodes 6 (push) and 7 (pop) use pointer X on the auxiliary memory with the same post-increment / pre-decrement rule. The address is the pointer value itself.
- R8: Opcodes 8 (push) and 9 (pop) use pointer Y with the same rule, but the auxiliary address is the bitwise inverse of the pointer. The first push after reset therefore writes address 255.
- R9: Every call opcode (0, 2, 4, 6, 8) writes the return address into the link register of the issuing task only. `lr_rd_data` shows the link register selected by `lr_rd_task`.
- R10: While a memory has not answered ready, `busy` stays high, that port's request, address and write enable hold steady, and new requests are ignored.
- R11: Pointers A, B, X and Y are shared by all tasks. A value pushed by one task can be popped by another.
- R12: Opcodes 10 to 15 are ignored. They produce no `done`, no `busy` and no change to any stack or link register.
- R13: After reset, `busy`, `done`, `next_pc` and all link registers are 0, and all pointers start at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_op | input | 4 | Opcode 0..9 (see R1-related requirements) |
| req_task | input | 2 | Issuing task |
| req_target | input | 16 | Call target |
| req_retaddr | input | 16 | Return address to save on a call |
| busy | output | 1 | A memory access is in progress |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 16 | Next program counter, valid with `done` |
| lr_rd_task | input | 2 | Task whose link register is read |
| lr_rd_data | output | 16 | Selected link register |
| sm_req | output | 1 | Shared memory request |
| sm_we | output | 1 | Shared memory write enable |
| sm_addr | output | 17 | Shared memory word address |
| sm_wdata | output | 16 | Shared memory write data |
| sm_ready | input | 1 | Shared memory completes the access |
| sm_rdata | input | 16 | Shared memory read data |
| ax_req | output | 1 | Auxiliary memory request |
| ax_we | output | 1 | Auxiliary memory write enable |
| ax_addr | output | 8 | Auxiliary memory word address |
| ax_wdata | output | 16 | Auxiliary memory write data |
| ax_ready | input | 1 | Auxiliary memory completes the access |
| ax_rdata | input | 16 | Auxiliary memory read data |

## Verification
The bench builds the unit with its defaults: four tasks, 4-entry shallow stacks, 17-bit shared pointers and 8-bit auxiliary pointers. Because the shallow stack is only 4 deep, a five-push sequence reaches both the overflow and the wrap corner in a few cycles. Because the auxiliary pointers are only 8 bits, the inverted Y address and the pointer wrap through zero are directly observable. Random opcode mixes with random memory latencies exercise pointer sharing between tasks and the overlap of stacks A and B in one memory.

// File: rtl/callret_pkg.sv
// Shared opcode and stack-kind definitions for the call/return unit.
// Assumes opcodes 0..9 are defined and 10..15 are reserved; bit 0 marks a return.
package callret_pkg;

    typedef enum logic [3:0] {
        OP_CALL  = 4'd0,
        OP_RET   = 4'd1,
        OP_CALLA = 4'd2,
        OP_RETA  = 4'd3,
        OP_CALLB = 4'd4,
        OP_RETB  = 4'd5,
        OP_CALLX = 4'd6,
        OP_RETX  = 4'd7,
        OP_CALLY = 4'd8,
        OP_RETY  = 4'd9
    } cr_op_e;

    typedef enum logic [2:0] {
        K_LIFO = 3'd0,
        K_A    = 3'd1,
        K_B    = 3'd2,
        K_X    = 3'd3,
        K_Y    = 3'd4
    } cr_kind_e;

    // True for defined opcodes only
    function automatic logic op_valid(input logic [3:0] op);
        return op <= 4'd9;
    endfunction

    // Stack discipline chosen by an opcode
    function automatic cr_kind_e op_kind(input logic [3:0] op);
        case (op[3:1])
            3'd0:    return K_LIFO;
            3'd1:    return K_A;
            3'd2:    return K_B;
            3'd3:    return K_X;
            default: return K_Y;
        endcase
    endfunction

endpackage

// File: rtl/cr_task_lifo.sv
// Shallow return stack of one task, kept as a circular buffer.
// Pushing onto a full stack overwrites the oldest slot; popping an empty stack
// returns the stale slot. The pointer wraps modulo DEPTH (DEPTH a power of two).
module cr_task_lifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] top_q
);
    localparam int SPW = $clog2(DEPTH);

    logic [DW-1:0]  slot_q [DEPTH];
    logic [SPW-1:0] sp_q;

    // Value a pop would return: the slot just below the pointer
    assign top_q = slot_q[sp_q - SPW'(1)];

    // Pointer update and slot write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (push) begin
            slot_q[sp_q] <= wdata;
            sp_q         <= sp_q + SPW'(1);
        end else if (pop) begin
            sp_q <= sp_q - SPW'(1);
        end
    end
endmodule

// File: rtl/cr_ptr_file.sv
// Pointer registers A, B (shared memory) and X, Y (auxiliary memory), common to
// all tasks. One pointer steps up or down per update, chosen by the stack kind.
module cr_ptr_file
    import callret_pkg::*;
#(
    parameter int SH_AW  = 17,
    parameter int AUX_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  cr_kind_e          sel,
    input  logic              dec,
    output logic [SH_AW-1:0]  ptr_a,
    output logic [SH_AW-1:0]  ptr_b,
    output logic [AUX_AW-1:0] ptr_x,
    output logic [AUX_AW-1:0] ptr_y
);
    localparam logic [SH_AW-1:0]  SH_ONE  = SH_AW'(1);
    localparam logic [AUX_AW-1:0] AUX_ONE = AUX_AW'(1);

    // Step the selected pointer after a completed memory access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_a <= '0;
            ptr_b <= '0;
            ptr_x <= '0;
            ptr_y <= '0;
        end else if (upd) begin
            case (sel)
                K_A:     ptr_a <= dec ? ptr_a - SH_ONE  : ptr_a + SH_ONE;
                K_B:     ptr_b <= dec ? ptr_b - SH_ONE  : ptr_b + SH_ONE;
                K_X:     ptr_x <= dec ? ptr_x - AUX_ONE : ptr_x + AUX_ONE;
                K_Y:     ptr_y <= dec ? ptr_y - AUX_ONE : ptr_y + AUX_ONE;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cr_link_bank.sv
// Link register banked per task: one write port, one read port.
// Assumes a single write per cycle.
module cr_link_bank #(
    parameter int NTASK = 4,
    parameter int DW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NTASK)-1:0] wr_task,
    input  logic [DW-1:0]            wr_data,
    input  logic [$clog2(NTASK)-1:0] rd_task,
    output logic [DW-1:0]            rd_data
);
    logic [DW-1:0] lr_q [NTASK];

    assign rd_data = lr_q[rd_task];

    // Record the return address of the calling task
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTASK; i++) lr_q[i] <= '0;
        end else if (wr_en) begin
            lr_q[wr_task] <= wr_data;
        end
    end
endmodule

// File: rtl/callret_unit.sv
// Call/return unit for a multi-task core.
// Shallow-stack calls and returns complete one cycle after acceptance. Pointer
// stack operations enter a memory state and finish on the memory's ready;
// the pointer changes only on completion, so the address holds while stalled.
// Assumes memories keep ready low until they serve the presented request.
module callret_unit
    import callret_pkg::*;
#(
    parameter int NTASK      = 4,
    parameter int LIFO_DEPTH = 4,
    parameter int DW         = 16,
    parameter int SH_AW      = 17,
    parameter int AUX_AW     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [3:0]               req_op,
    input  logic [$clog2(NTASK)-1:0] req_task,
    input  logic [DW-1:0]            req_target,
    input  logic [DW-1:0]            req_retaddr,
    output logic                     busy,
    output logic                     done,
    output logic [DW-1:0]            next_pc,
    input  logic [$clog2(NTASK)-1:0] lr_rd_task,
    output logic [DW-1:0]            lr_rd_data,
    output logic                     sm_req,
    output logic                     sm_we,
    output logic [SH_AW-1:0]         sm_addr,
    output logic [DW-1:0]            sm_wdata,
    input  logic                     sm_ready,
    input  logic [DW-1:0]            sm_rdata,
    output logic                     ax_req,
    output logic                     ax_we,
    output logic [AUX_AW-1:0]        ax_addr,
    output logic [DW-1:0]            ax_wdata,
    input  logic                     ax_ready,
    input  logic [DW-1:0]            ax_rdata
);
    localparam int TW = $clog2(NTASK);

    typedef enum logic {ST_IDLE, ST_MEM} state_e;

    state_e          state_q;
    cr_kind_e        kind_q;
    logic            ret_q;
    logic [TW-1:0]   task_q;
    logic [DW-1:0]   tgt_q;
    logic [DW-1:0]   rad_q;
    logic            done_q;
    logic [DW-1:0]   pc_q;

    cr_kind_e        req_kind;
    logic            req_is_ret;
    logic            accept;
    logic            lifo_push;
    logic            lifo_pop;
    logic [DW-1:0]   lifo_top [NTASK];

    logic [SH_AW-1:0]  ptr_a, ptr_b, cur_sh;
    logic [AUX_AW-1:0] ptr_x, ptr_y, cur_ax, raw_ax;
    logic              on_shared;
    logic              mem_done;

    logic              lr_wr_en;
    logic [TW-1:0]     lr_wr_task;

    // Request decode and acceptance
    assign req_kind   = op_kind(req_op);
    assign req_is_ret = req_op[0];
    assign busy       = (state_q == ST_MEM);
    assign accept     = req_valid && !busy && op_valid(req_op);
    assign lifo_push  = accept && (req_kind == K_LIFO) && !req_is_ret;
    assign lifo_pop   = accept && (req_kind == K_LIFO) &&  req_is_ret;

    // One shallow stack per task
    for (genvar t = 0; t < NTASK; t++) begin : g_lifo
        cr_task_lifo #(
            .DEPTH (LIFO_DEPTH),
            .DW    (DW)
        ) u_lifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (lifo_push && (req_task == TW'(t))),
            .pop   (lifo_pop  && (req_task == TW'(t))),
            .wdata (req_retaddr),
            .top_q (lifo_top[t])
        );
    end

    // Shared pointers
    cr_ptr_file #(
        .SH_AW  (SH_AW),
        .AUX_AW (AUX_AW)
    ) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (mem_done),
        .sel   (kind_q),
        .dec   (ret_q),
        .ptr_a (ptr_a),
        .ptr_b (ptr_b),
        .ptr_x (ptr_x),
        .ptr_y (ptr_y)
    );

    // Memory address formation: post-increment push, pre-decrement pop, Y inverted
    assign on_shared = (kind_q == K_A) || (kind_q == K_B);
    assign cur_sh    = (kind_q == K_B) ? ptr_b : ptr_a;
    assign cur_ax    = (kind_q == K_Y) ? ptr_y : ptr_x;
    assign raw_ax    = ret_q ? cur_ax - AUX_AW'(1) : cur_ax;

    assign sm_req    = busy && on_shared;
    assign sm_we     = !ret_q;
    assign sm_addr   = ret_q ? cur_sh - SH_AW'(1) : cur_sh;
    assign sm_wdata  = rad_q;

    assign ax_req    = busy && !on_shared;
    assign ax_we     = !ret_q;
    assign ax_addr   = (kind_q == K_Y) ? ~raw_ax : raw_ax;
    assign ax_wdata  = rad_q;

    assign mem_done  = on_shared ? sm_req && sm_ready : ax_req && ax_ready;

    // Link register write on every call, at its completion
    assign lr_wr_en   = lifo_push || (mem_done && !ret_q);
    assign lr_wr_task = busy ? task_q : req_task;

    cr_link_bank #(
        .NTASK (NTASK),
        .DW    (DW)
    ) u_links (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lr_wr_en),
        .wr_task (lr_wr_task),
        .wr_data (busy ? rad_q : req_retaddr),
        .rd_task (lr_rd_task),
        .rd_data (lr_rd_data)
    );

    // Control state, request capture and registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_LIFO;
            ret_q   <= 1'b0;
            task_q  <= '0;
            tgt_q   <= '0;
            rad_q   <= '0;
            done_q  <= 1'b0;
            pc_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                kind_q <= req_kind;
                ret_q  <= req_is_ret;
                task_q <= req_task;
                tgt_q  <= req_target;
                rad_q  <= req_retaddr;
                if (req_kind == K_LIFO) begin
                    done_q <= 1'b1;
                    pc_q   <= req_is_ret ? lifo_top[req_task] : req_target;
                end else begin
                    state_q <= ST_MEM;
                end
            end else if (mem_done) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
                if (!ret_q)         pc_q <= tgt_q;
                else if (on_shared) pc_q <= sm_rdata;
                else                pc_q <= ax_rdata;
            end
        end
    end

    assign done    = done_q;
    assign next_pc = pc_q;
endmodule

// File: rtl/callret_checker.sv
// Temporal checks on the call/return unit, bound to every instance.
module callret_checker
    import callret_pkg::*;
#(
    parameter int DW     = 16,
    parameter int SH_AW  = 17,
    parameter int AUX_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        req_op,
    input logic [DW-1:0]     req_target,
    input logic              busy,
    input logic              done,
    input logic [DW-1:0]     next_pc,
    input logic              sm_req,
    input logic              sm_we,
    input logic [SH_AW-1:0]  sm_addr,
    input logic              sm_ready,
    input logic [DW-1:0]     sm_rdata,
    input logic              ax_req,
    input logic              ax_we,
    input logic [AUX_AW-1:0] ax_addr,
    input logic              ax_ready,
    input logic [DW-1:0]     ax_rdata
);
    p_call_pc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == OP_CALL) |=>
            (done && !busy && next_pc == $past(req_target)));

    p_ret_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op == OP_RET) |=> (done && !busy));

    p_sm_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_req && sm_ready && !sm_we) |=> (done && next_pc == $past(sm_rdata)));

    p_ax_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_req && ax_ready && !ax_we) |=> (done && next_pc == $past(ax_rdata)));

    p_sm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sm_req && !sm_ready) |=> (sm_req && busy && $stable(sm_addr) && $stable(sm_we)));

    p_ax_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_req && !ax_ready) |=> (ax_req && busy && $stable(ax_addr) && $stable(ax_we)));

    p_one_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sm_req, ax_req}));

    p_bad_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_op > 4'd9) |=> (!done && !busy));
endmodule

bind callret_unit callret_checker #(
    .DW     (DW),
    .SH_AW  (SH_AW),
    .AUX_AW (AUX_AW)
) i_callret_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_target (req_target),
    .busy       (busy),
    .done       (done),
    .next_pc    (next_pc),
    .sm_req     (sm_req),
    .sm_we      (sm_we),
    .sm_addr    (sm_addr),
    .sm_ready   (sm_ready),
    .sm_rdata   (sm_rdata),
    .ax_req     (ax_req),
    .ax_we      (ax_we),
    .ax_addr    (ax_addr),
    .ax_ready   (ax_ready),
    .ax_rdata   (ax_rdata)
);

// File: tb/test_callret_unit.sv
// Bench: directed corner cases followed by seeded random opcode mixes,
// compared against a reference model of stacks, pointers and link registers.
module test_callret_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = '0;
    logic [1:0]  req_task = '0;
    logic [15:0] req_target = '0;
    logic [15:0] req_retaddr = '0;
    logic        busy, done;
    logic [15:0] next_pc;
    logic [1:0]  lr_rd_task = '0;
    logic [15:0] lr_rd_data;
    logic        sm_req, sm_we, ax_req, ax_we;
    logic [16:0] sm_addr;
    logic [7:0]  ax_addr;
    logic [15:0] sm_wdata, ax_wdata;
    logic        sm_ready = 1'b0, ax_ready = 1'b0;
    logic [15:0] sm_rdata = '0, ax_rdata = '0;

    always #10 clk = ~clk;

    callret_unit i_callret_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_task(req_task), .req_target(req_target), .req_retaddr(req_retaddr),
        .busy(busy), .done(done), .next_pc(next_pc),
        .lr_rd_task(lr_rd_task), .lr_rd_data(lr_rd_data),
        .sm_req(sm_req), .sm_we(sm_we), .sm_addr(sm_addr), .sm_wdata(sm_wdata),
        .sm_ready(sm_ready), .sm_rdata(sm_rdata),
        .ax_req(ax_req), .ax_we(ax_we), .ax_addr(ax_addr), .ax_wdata(ax_wdata),
        .ax_ready(ax_ready), .ax_rdata(ax_rdata)
    );

    int n_checks = 0;
    int n_errors = 0;

    // Memory models and responder state
    logic [15:0] shm [1024];
    logic [15:0] axm [256];
    logic        hold_sm = 1'b0;
    int          sm_wait = 0, ax_wait = 0;
    logic [16:0] seen_sm_addr;
    logic [7:0]  seen_ax_addr;
    logic        seen_we;
    logic [15:0] seen_wdata;

    // Reference model
    logic [15:0] ref_lifo [4][4];
    logic [1:0]  ref_sp [4];
    logic [15:0] ref_sh [1024];
    logic [15:0] ref_aux [256];
    logic [15:0] ref_lr [4];
    logic [16:0] r_a, r_b;
    logic [7:0]  r_x, r_y;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shared memory responder with random latency
    always @(negedge clk) begin
        if (sm_req && !sm_ready && !hold_sm) begin
            if (sm_wait == 0) begin
                sm_ready     = 1'b1;
                sm_rdata     = shm[sm_addr[9:0]];
                if (sm_we) shm[sm_addr[9:0]] = sm_wdata;
                seen_sm_addr = sm_addr;
                seen_we      = sm_we;
                seen_wdata   = sm_wdata;
            end else sm_wait--;
        end else begin
            sm_ready = 1'b0;
            sm_wait  = int'($urandom % 3);
        end
    end

    // Auxiliary memory responder with random latency
    always @(negedge clk) begin
        if (ax_req && !ax_ready) begin
            if (ax_wait == 0) begin
                ax_ready     = 1'b1;
                ax_rdata     = axm[ax_addr];
                if (ax_we) axm[ax_addr] = ax_wdata;
                seen_ax_addr = ax_addr;
                seen_we      = ax_we;
                seen_wdata   = ax_wdata;
            end else ax_wait--;
        end else begin
            ax_ready = 1'b0;
            ax_wait  = int'($urandom % 3);
        end
    end

    // Issue one request and wait for its completion pulse
    task automatic do_op(input logic [3:0] op, input logic [1:0] tk,
                         input logic [15:0] tgt, input logic [15:0] ra);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_task = tk;
        req_target = tgt; req_retaddr = ra;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
    endtask

    // Run one op against the model and check result, address and link register
    task automatic run_op(input logic [3:0] op, input logic [1:0] tk,
                          input logic [15:0] tgt, input logic [15:0] ra);
        logic [15:0] exp_pc;
        logic [16:0] exp_addr;
        string       tag;
        exp_pc = tgt; exp_addr = '0;
        case (op)
            4'd0: begin tag = "R1"; ref_lifo[tk][ref_sp[tk]] = ra; ref_sp[tk]++; end
            4'd1: begin tag = "R2"; ref_sp[tk]--; exp_pc = ref_lifo[tk][ref_sp[tk]]; end
            4'd2: begin tag = "R5"; exp_addr = r_a; ref_sh[r_a[9:0]] = ra; r_a++; end
            4'd3: begin tag = "R6"; r_a--; exp_addr = r_a; exp_pc = ref_sh[r_a[9:0]]; end
            4'd4: begin tag = "R5"; exp_addr = r_b; ref_sh[r_b[9:0]] = ra; r_b++; end
            4'd5: begin tag = "R6"; r_b--; exp_addr = r_b; exp_pc = ref_sh[r_b[9:0]]; end
            4'd6: begin tag = "R7"; exp_addr = {9'd0, r_x}; ref_aux[r_x] = ra; r_x++; end
            4'd7: begin tag = "R7"; r_x--; exp_addr = {9'd0, r_x}; exp_pc = ref_aux[r_x]; end
            4'd8: begin tag = "R8"; exp_addr = {9'd0, ~r_y}; ref_aux[~r_y] = ra; r_y++; end
            default: begin tag = "R8"; r_y--; exp_addr = {9'd0, ~r_y}; exp_pc = ref_aux[~r_y]; end
        endcase
        do_op(op, tk, tgt, ra);
        chk({tag, " next_pc"}, 32'(next_pc), 32'(exp_pc));
        if (op >= 4'd2 && op <= 4'd5) begin
            chk({tag, " shared addr"}, 32'(seen_sm_addr), 32'(exp_addr));
            chk({tag, " write enable"}, 32'(seen_we), 32'(!op[0]));
        end else if (op >= 4'd6) begin
            chk({tag, " aux addr"}, 32'(seen_ax_addr), 32'(exp_addr));
            chk({tag, " write enable"}, 32'(seen_we), 32'(!op[0]));
        end
        if (!op[0]) begin
            ref_lr[tk] = ra;
            if (op != 4'd0) chk({tag, " write data"}, 32'(seen_wdata), 32'(ra));
            lr_rd_task = tk; #1;
            chk("R9 link register", 32'(lr_rd_data), 32'(ra));
        end
    endtask

    // Watchdog: a hung run counts as one failure
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) begin shm[i] = '0; ref_sh[i] = '0; end
        for (int i = 0; i < 256; i++) begin axm[i] = '0; ref_aux[i] = '0; end
        for (int t = 0; t < 4; t++) begin
            ref_sp[t] = '0; ref_lr[t] = '0;
            for (int k = 0; k < 4; k++) ref_lifo[t][k] = '0;
        end
        r_a = '0; r_b = '0; r_x = '0; r_y = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state
        chk("R13 busy", 32'(busy), 0);
        chk("R13 done", 32'(done), 0);
        chk("R13 next_pc", 32'(next_pc), 0);
        for (int t = 0; t < 4; t++) begin
            lr_rd_task = 2'(t); #1;
            chk("R13 link register", 32'(lr_rd_data), 0);
        end

        // R8: first Y push lands at the top address
        run_op(4'd8, 2'd0, 16'h1000, 16'hA001);
        chk("R8 first push address", 32'(seen_ax_addr), 32'hFF);
        // R13: A pointer starts at 0
        run_op(4'd2, 2'd0, 16'h1100, 16'hA002);
        chk("R13 first shared address", 32'(seen_sm_addr), 0);

        // R3, R4: overflow and wrap on task 2
        for (int i = 0; i < 5; i++) run_op(4'd0, 2'd2, 16'h2000, 16'h0100 + 16'(i));
        run_op(4'd1, 2'd2, 16'h0, 16'h0); chk("R3 pop 1", 32'(next_pc), 32'h0104);
        run_op(4'd1, 2'd2, 16'h0, 16'h0); chk("R3 pop 2", 32'(next_pc), 32'h0103);
        run_op(4'd1, 2'd2, 16'h0, 16'h0); chk("R3 pop 3", 32'(next_pc), 32'h0102);
        run_op(4'd1, 2'd2, 16'h0, 16'h0); chk("R3 pop 4", 32'(next_pc), 32'h0101);
        run_op(4'd1, 2'd2, 16'h0, 16'h0); chk("R4 wrapped pop", 32'(next_pc), 32'h0104);

        // R11: task 0 pushes on A, task 3 pops it
        run_op(4'd2, 2'd0, 16'h3000, 16'h0055);
        run_op(4'd3, 2'd3, 16'h0, 16'h0);
        chk("R11 cross-task pop", 32'(next_pc), 32'h0055);

        // R10: stall on B, a request during the stall is ignored
        hold_sm = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'd4; req_task = 2'd1;
        req_target = 16'h2222; req_retaddr = 16'h3333;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 busy while stalled", 32'(busy), 1);
        chk("R10 address held", 32'(sm_addr), 32'(r_b));
        req_valid = 1'b1; req_op = 4'd0; req_target = 16'h7777; req_retaddr = 16'h7778;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 still busy", 32'(busy), 1);
        hold_sm = 1'b0;
        while (!done) @(negedge clk);
        chk("R10 stalled call result", 32'(next_pc), 32'h2222);
        ref_sh[r_b[9:0]] = 16'h3333; r_b++; ref_lr[1] = 16'h3333;
        @(negedge clk);
        chk("R10 ignored request no done", 32'(done), 0);
        lr_rd_task = 2'd1; #1;
        chk("R10 ignored request link", 32'(lr_rd_data), 32'h3333);

        // R12: reserved opcode has no effect
        @(negedge clk);
        req_valid = 1'b1; req_op = 4'd12; req_task = 2'd1;
        req_target = 16'h4444; req_retaddr = 16'h5555;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R12 no done", 32'(done), 0);
        chk("R12 no busy", 32'(busy), 0);
        @(negedge clk);
        chk("R12 still no done", 32'(done), 0);
        lr_rd_task = 2'd1; #1;
        chk("R12 link unchanged", 32'(lr_rd_data), 32'h3333);
        run_op(4'd1, 2'd1, 16'h0, 16'h0);

        // Random mixes across all opcodes and tasks
        for (int n = 0; n < 400; n++) begin
            run_op(4'($urandom % 10), 2'($urandom % 4),
                   16'($urandom), 16'($urandom));
        end

        // R9: final link registers of every task
        for (int t = 0; t < 4; t++) begin
            lr_rd_task = 2'(t); #1;
            chk("R9 final link register", 32'(lr_rd_data), 32'(ref_lr[t]));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule